// File: doc/BRIEF.md
# Serial Byte Receiver with Parity Failure Policy

This block turns an asynchronous serial line into bytes. A frame is one low start bit, eight data bits sent least significant bit first, an optional parity bit, and one high stop bit. The bit period in clock cycles is the ratio of two parameters, the clock frequency and the bit rate (default 115200 bit/s). An optional two-flop synchronizer can sit on the line input when the line comes from another clock domain.

The parity mode is fixed at build time as none, even or odd. When a received parity bit does not match, a policy parameter picks what happens. Passthrough forwards the byte as it arrived. Replace forwards a fixed marker byte (default 0x15) instead. Drop emits no byte at all. In every case the parity error flag pulses. A stop bit sampled low raises a framing error flag next to the byte. The receiver then waits for the line to go high again before it looks for the next start bit.

Each result comes out as a one-cycle pulse on the valid output. The byte and both flags are registered and appear in the same cycle.

Top module: `uart_rx_policy`

## Requirements
- R1: In the cycle after a reset edge, byte_valid, parity_err and frame_err are all 0.
- R2: Each frame produces exactly one byte. The eight data bits are sampled near mid-bit and the first data bit is bit 0 of byte_data.
- R3: A low pulse on the line shorter than half a bit period produces no output and no error flag.
- R4: In even mode the frame carries a parity bit after bit 7. A frame whose data bits plus parity bit hold an odd number of ones raises parity_err.
- R5: In odd mode the frame carries a parity bit after bit 7. A frame whose data bits plus parity bit hold an even number of ones raises parity_err.
- R6: With parity set to none, the stop bit follows bit 7 directly and parity_err is never raised.
- R7: Under the passthrough policy a parity-failed byte is output unchanged, with parity_err high in the same cycle as byte_valid.
- R8: Under the replace policy a parity-failed frame outputs the marker byte (default 0x15) with parity_err high.
- R9: Under the drop policy a parity-failed frame gives a one-cycle parity_err pulse and no byte_valid.
- R10: A stop bit sampled low sets frame_err with the result. The byte is still output unless it is dropped under R9. The next frame after the line returns high is received correctly.
- R11: With the input synchronizer disabled, bytes and flags are the same as with it enabled.
- R12: byte_valid, parity_err and frame_err are single-cycle pulses. byte_data changes only in a cycle where byte_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_in | input | 1 | Serial line, idle high |
| byte_valid | output | 1 | One-cycle pulse: a byte is on byte_data |
| byte_data | output | 8 | Received byte, or the marker under replace |
| parity_err | output | 1 | One-cycle pulse: parity mismatch on this frame |
| frame_err | output | 1 | One-cycle pulse: stop bit was low on this frame |

## Verification
Two outcomes can land in the same result cycle: a parity mismatch and a low stop bit. When both happen, the chosen policy has to decide about the byte while the framing flag is still reported. The bench provokes this with directed frames that flip the parity bit and hold the stop bit low together, on a drop-policy instance and in random traffic on every instance. For each frame it counts valid pulses and flag pulses and compares the counts with values derived from the requirements: no byte and two flags under drop, and a marker or unchanged byte with both flags under the other policies.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic [1:0] {PAR_NONE, PAR_EVEN, PAR_ODD} par_mode_e;
  typedef enum logic [1:0] {POL_PASS, POL_REPLACE, POL_DROP} par_policy_e;
  typedef enum logic [2:0] {FS_IDLE, FS_START, FS_DATA, FS_PAR, FS_STOP, FS_BREAK} frm_state_e;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter bit ENABLE = 1'b1,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (ENABLE) begin : g_sync
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
      assign dout = chain[STAGES-1];
    end else begin : g_bypass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/urx_bit_timer.sv
module urx_bit_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/urx_framer.sv
module urx_framer #(
  parameter int BIT_CYC = 16,
  parameter bit HAS_PAR = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line,
  output logic       fr_done,
  output logic [7:0] fr_data,
  output logic       fr_pbit,
  output logic       fr_stop_bad
);
  import urx_pkg::*;

  localparam int HALF = BIT_CYC / 2;
  localparam int CW   = $clog2(BIT_CYC);

  frm_state_e    st;
  logic [2:0]    bit_idx;
  logic [7:0]    sr;
  logic          load;
  logic [CW-1:0] load_val;
  logic          expired;

  urx_bit_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
  );

  always_comb begin
    load     = 1'b0;
    load_val = CW'(BIT_CYC - 1);
    unique case (st)
      FS_IDLE: begin
        load     = !line;
        load_val = CW'(HALF - 1);
      end
      FS_START: load = expired && !line;
      FS_DATA:  load = expired;
      FS_PAR:   load = expired;
      default:  load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= FS_IDLE;
      bit_idx     <= '0;
      sr          <= '0;
      fr_done     <= 1'b0;
      fr_data     <= '0;
      fr_pbit     <= 1'b0;
      fr_stop_bad <= 1'b0;
    end else begin
      fr_done <= 1'b0;
      unique case (st)
        FS_IDLE: begin
          if (!line) st <= FS_START;
        end
        FS_START: begin
          if (expired) begin
            bit_idx <= '0;
            st      <= line ? FS_IDLE : FS_DATA;
          end
        end
        FS_DATA: begin
          if (expired) begin
            sr      <= {line, sr[7:1]};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) st <= HAS_PAR ? FS_PAR : FS_STOP;
          end
        end
        FS_PAR: begin
          if (expired) begin
            fr_pbit <= line;
            st      <= FS_STOP;
          end
        end
        FS_STOP: begin
          if (expired) begin
            fr_done     <= 1'b1;
            fr_data     <= sr;
            fr_stop_bad <= !line;
            st          <= line ? FS_IDLE : FS_BREAK;
          end
        end
        default: begin
          if (line) st <= FS_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/urx_policy.sv
module urx_policy #(
  parameter urx_pkg::par_mode_e   PAR_MODE = urx_pkg::PAR_NONE,
  parameter urx_pkg::par_policy_e POLICY   = urx_pkg::POL_PASS,
  parameter logic [7:0]           MARK     = 8'h15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fr_done,
  input  logic [7:0] fr_data,
  input  logic       fr_pbit,
  input  logic       fr_stop_bad,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       parity_err,
  output logic       frame_err
);
  import urx_pkg::*;

  logic bad_par;
  logic keep;

  always_comb begin
    unique case (PAR_MODE)
      PAR_EVEN: bad_par = (^fr_data) ^ fr_pbit;
      PAR_ODD:  bad_par = !((^fr_data) ^ fr_pbit);
      default:  bad_par = 1'b0;
    endcase
    keep = !(POLICY == POL_DROP && bad_par);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      byte_valid <= fr_done && keep;
      parity_err <= fr_done && bad_par;
      frame_err  <= fr_done && fr_stop_bad;
      if (fr_done && keep)
        byte_data <= (POLICY == POL_REPLACE && bad_par) ? MARK : fr_data;
    end
  end
endmodule

// File: rtl/uart_rx_policy.sv
module uart_rx_policy #(
  parameter int                   CLK_HZ   = 100_000_000,
  parameter int                   BAUD     = 115_200,
  parameter urx_pkg::par_mode_e   PAR_MODE = urx_pkg::PAR_NONE,
  parameter urx_pkg::par_policy_e POLICY   = urx_pkg::POL_PASS,
  parameter logic [7:0]           MARK     = 8'h15,
  parameter bit                   SYNC_EN  = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd_in,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       parity_err,
  output logic       frame_err
);
  localparam int BIT_CYC = CLK_HZ / BAUD;
  localparam bit HAS_PAR = (PAR_MODE != urx_pkg::PAR_NONE);

  logic       line;
  logic       fr_done;
  logic [7:0] fr_data;
  logic       fr_pbit;
  logic       fr_stop_bad;

  urx_sync #(.ENABLE(SYNC_EN), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(rxd_in), .dout(line)
  );

  urx_framer #(.BIT_CYC(BIT_CYC), .HAS_PAR(HAS_PAR)) u_frm (
    .clk(clk), .rst(rst), .line(line),
    .fr_done(fr_done), .fr_data(fr_data), .fr_pbit(fr_pbit), .fr_stop_bad(fr_stop_bad)
  );

  urx_policy #(.PAR_MODE(PAR_MODE), .POLICY(POLICY), .MARK(MARK)) u_pol (
    .clk(clk), .rst(rst),
    .fr_done(fr_done), .fr_data(fr_data), .fr_pbit(fr_pbit), .fr_stop_bad(fr_stop_bad),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .parity_err(parity_err), .frame_err(frame_err)
  );
endmodule

// File: rtl/urx_chk.sv
module urx_chk #(
  parameter urx_pkg::par_mode_e   PAR_MODE = urx_pkg::PAR_NONE,
  parameter urx_pkg::par_policy_e POLICY   = urx_pkg::POL_PASS,
  parameter logic [7:0]           MARK     = 8'h15
) (
  input logic       clk,
  input logic       rst,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       parity_err,
  input logic       frame_err
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!byte_valid && !parity_err && !frame_err));

  p_valid_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  p_perr_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    parity_err |=> !parity_err);

  p_ferr_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  p_data_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(byte_data) |-> byte_valid);

  generate
    if (PAR_MODE == urx_pkg::PAR_NONE) begin : g_none
      p_no_perr_r6: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> !parity_err);
    end
    if (POLICY == urx_pkg::POL_DROP) begin : g_drop
      p_drop_silent_r9: assert property (@(posedge clk) disable iff (rst)
        parity_err |-> !byte_valid);
    end else begin : g_keep
      p_flag_with_byte_r7: assert property (@(posedge clk) disable iff (rst)
        (parity_err || frame_err) |-> byte_valid);
    end
    if (POLICY == urx_pkg::POL_REPLACE) begin : g_repl
      p_marker_r8: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && parity_err) |-> (byte_data == MARK));
    end
  endgenerate
endmodule

bind uart_rx_policy urx_chk #(.PAR_MODE(PAR_MODE), .POLICY(POLICY), .MARK(MARK)) u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
  .parity_err(parity_err), .frame_err(frame_err)
);

// File: tb/sim_uart_rx_policy.sv
`timescale 1ns/1ps
module sim_uart_rx_policy;
  import urx_pkg::*;

  localparam int CLK_HZ = 3_200_000;
  localparam int BAUD   = 200_000;
  localparam int BITC   = CLK_HZ / BAUD;
  localparam logic [7:0] MARKB = 8'h15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] rx = 4'hF;
  logic [3:0] vld, perr, ferr;
  logic [7:0] dat [4];

  int nchk = 0, nerr = 0;
  int nv [4], np [4], nf [4];
  logic [7:0] last [4];
  bit finished = 0;

  always #2.5 clk = ~clk;

  // u0: even/replace, u1: odd/drop, u2: odd/pass no sync, u3: none/pass
  uart_rx_policy #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .PAR_MODE(PAR_EVEN), .POLICY(POL_REPLACE),
    .MARK(MARKB), .SYNC_EN(1'b1)) u0 (.clk(clk), .rst(rst), .rxd_in(rx[0]),
    .byte_valid(vld[0]), .byte_data(dat[0]), .parity_err(perr[0]), .frame_err(ferr[0]));
  uart_rx_policy #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .PAR_MODE(PAR_ODD), .POLICY(POL_DROP),
    .MARK(MARKB), .SYNC_EN(1'b1)) u1 (.clk(clk), .rst(rst), .rxd_in(rx[1]),
    .byte_valid(vld[1]), .byte_data(dat[1]), .parity_err(perr[1]), .frame_err(ferr[1]));
  uart_rx_policy #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .PAR_MODE(PAR_ODD), .POLICY(POL_PASS),
    .MARK(MARKB), .SYNC_EN(1'b0)) u2 (.clk(clk), .rst(rst), .rxd_in(rx[2]),
    .byte_valid(vld[2]), .byte_data(dat[2]), .parity_err(perr[2]), .frame_err(ferr[2]));
  uart_rx_policy #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .PAR_MODE(PAR_NONE), .POLICY(POL_PASS),
    .MARK(MARKB), .SYNC_EN(1'b1)) u3 (.clk(clk), .rst(rst), .rxd_in(rx[3]),
    .byte_valid(vld[3]), .byte_data(dat[3]), .parity_err(perr[3]), .frame_err(ferr[3]));

  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (vld[k])  begin nv[k]++; last[k] = dat[k]; end
      if (perr[k]) np[k]++;
      if (ferr[k]) nf[k]++;
    end
  end

  function automatic par_mode_e mode_of(int ch);
    return (ch == 0) ? PAR_EVEN : (ch == 3) ? PAR_NONE : PAR_ODD;
  endfunction
  function automatic par_policy_e pol_of(int ch);
    return (ch == 0) ? POL_REPLACE : (ch == 1) ? POL_DROP : POL_PASS;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(int ch, logic v);
    rx[ch] = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic frame_check(int ch, logic [7:0] d, bit flip, bit stopv, string tag);
    int v0, p0, f0;
    bit use_par, pbit, bad, keep;
    logic [7:0] expd;
    use_par = (mode_of(ch) != PAR_NONE);
    pbit = (mode_of(ch) == PAR_ODD) ? ~^d : ^d;
    if (flip) pbit = ~pbit;
    bad  = use_par && flip;
    keep = !(pol_of(ch) == POL_DROP && bad);
    expd = (pol_of(ch) == POL_REPLACE && bad) ? MARKB : d;
    v0 = nv[ch]; p0 = np[ch]; f0 = nf[ch];
    @(negedge clk);
    drive_bit(ch, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(ch, d[i]);
    if (use_par) drive_bit(ch, pbit);
    drive_bit(ch, stopv);
    drive_bit(ch, 1'b1);
    drive_bit(ch, 1'b1);
    chk(nv[ch] - v0 == int'(keep), {tag, " valid count"}, nv[ch] - v0, int'(keep));
    chk(np[ch] - p0 == int'(bad), {tag, " parity flag count"}, np[ch] - p0, int'(bad));
    chk(nf[ch] - f0 == int'(!stopv), {tag, " frame flag count"}, nf[ch] - f0, int'(!stopv));
    if (keep) chk(last[ch] == expd, {tag, " data"}, last[ch], expd);
  endtask

  task automatic glitch_check(int ch, int width);
    int v0, p0, f0;
    v0 = nv[ch]; p0 = np[ch]; f0 = nf[ch];
    @(negedge clk);
    rx[ch] = 1'b0;
    repeat (width) @(negedge clk);
    rx[ch] = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    chk((nv[ch] - v0) + (np[ch] - p0) + (nf[ch] - f0) == 0, "R3 glitch ignored",
        (nv[ch] - v0) + (np[ch] - p0) + (nf[ch] - f0), 0);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin nv[k] = 0; np[k] = 0; nf[k] = 0; last[k] = '0; end
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    // R1: outputs quiet while reset has been applied
    chk(vld == 4'h0 && perr == 4'h0 && ferr == 4'h0, "R1 reset outputs",
        {vld, perr, ferr}, 0);
    rst = 1'b0;
    repeat (BITC) @(negedge clk);

    frame_check(3, 8'hA5, 0, 1, "R2 none-mode byte");
    frame_check(3, 8'h01, 0, 1, "R2 lsb first 01");
    frame_check(3, 8'h80, 0, 1, "R2 lsb first 80");
    frame_check(3, 8'h00, 1, 1, "R6 no parity bit");
    frame_check(0, 8'h3C, 0, 1, "R4 even clean");
    frame_check(0, 8'h3D, 1, 1, "R4 R8 even fail replaced");
    frame_check(1, 8'h7E, 0, 1, "R5 odd clean");
    frame_check(1, 8'h7F, 1, 1, "R5 R9 odd fail dropped");
    frame_check(2, 8'hC3, 1, 1, "R7 R11 passthrough unsynced");
    frame_check(2, 8'h5A, 0, 1, "R11 unsynced clean");
    frame_check(3, 8'h55, 0, 0, "R10 low stop");
    frame_check(3, 8'h99, 0, 1, "R10 recovery");
    frame_check(1, 8'h12, 1, 0, "R9 R10 drop with low stop");
    frame_check(0, 8'hF0, 1, 0, "R8 R10 replace with low stop");
    for (int k = 0; k < 4; k++) glitch_check(k, BITC / 2 - 3);
    frame_check(0, 8'h66, 0, 1, "R3 after glitch");

    for (int n = 0; n < 25; n++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d;
        bit flip, stopv;
        d     = 8'($urandom);
        flip  = ($urandom % 4) == 0;
        stopv = ($urandom % 6) != 0;
        frame_check(k, d, flip, stopv, "R12 random frame");
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule